// File: doc/BRIEF.md
# Bus Request Signal Generator

This block drives the bus-request line of a bus master that keeps the bus parked. When nothing holds the master off the bus, it starts cycles on its own with no arbitration handshake. Normal activity raises the request for one clock only. That activity is a new bus cycle, a cache store or a cache-tag recovery. System arbitration logic can see these pulses and safely ignore them.

The request becomes a held level only when a hold-off input is active and the master reports that it cannot continue from its cache. In that case the request stays high until every hold-off input has dropped. A cycle start that arrives while the master is blocked is kept as pending. Its address strobe is issued, together with a request pulse, one clock after the hold-off ends. In the low-power and stopped states, and during reset or init, both outputs stay low.

Both outputs are registered. An input that is sampled at clock edge k affects the outputs from edge k onward. This block has no data path, so every pin is a plain control signal with no back-pressure.

Top module: `busreq_gen`

## Requirements
- R1: When `cyc_start` is sampled high, no hold-off bit is set, nothing is pending and no quiet condition holds, `ads` and `bus_req` are both high for the following cycle. Each sampled strobe gives one such cycle, including back-to-back strobes.
- R2: A rising edge of `cache_store` or of `tag_recover` gives a one-cycle `bus_req` pulse with `ads` low. Keeping the input high produces no further pulses.
- R3: While any `hold_off` bit is set and `starved` is high, `bus_req` is high in every following cycle. Once this level has started, it stays high even if `starved` drops, until all `hold_off` bits are zero.
- R4: Suppose a cycle is pending and edge k is the first edge at which all `hold_off` bits are zero. Then `ads` and `bus_req` are low after edge k and both high for exactly one cycle after edge k+1.
- R5: When any `sleep_st` bit is set at an edge, `bus_req` and `ads` are low after that edge. This holds for every bit: bit 0 shutdown, bit 1 halt, bit 2 stop-grant, bit 3 stop-clock. The same applies while `init` is high. Cycle starts sampled in a sleep state are dropped.
- R6: Synchronous `rst` and `init` both clear the pending cycle and the held level, and force both outputs low. No strobe follows later.
- R7: A `cyc_start` sampled while any `hold_off` bit is set is recorded as pending and does not drive `ads` at that point. Several starts merge into one pending cycle.
- R8: A pending cycle survives a sleep state. Its restart follows R4, counted from the first edge that is both unblocked and not asleep.
- R9: While the master is blocked but not starved, cache-store and tag-recovery pulses still appear on `bus_req`.
- R10: Suppose a hold-off bit is set again at the edge where the restart strobe was due. Then no strobe is issued, and the restart is retried after the next negation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init | input | 1 | Synchronous init, active high |
| sleep_st | input | N_SLEEP | Quiet state flags: shutdown, halt, stop-grant, stop-clock |
| hold_off | input | N_HOLD | Hold-off inputs: address hold, backoff, bus hold |
| starved | input | 1 | Master cannot continue from its cache |
| cyc_start | input | 1 | One-clock strobe asking to start a bus cycle |
| cache_store | input | 1 | Cache store in progress (level) |
| tag_recover | input | 1 | Cache-tag recovery in progress (level) |
| bus_req | output | 1 | Bus request |
| ads | output | 1 | Address strobe of a started cycle |

## Verification
The bench builds the block with the default values N_HOLD = 3 and N_SLEEP = 4. With these values each hold-off input and each quiet state flag can be driven by its own pin. The stimulus table covers several hold-off bits overlapping, each of the four quiet states, a pending cycle that is carried across a quiet state, and a hold-off that is raised again at the moment of restart. Directed tests then measure how long the request level lasts over a twenty-cycle hold-off and how long the restart takes after negation.

// File: rtl/busreq_pkg.sv
package busreq_pkg;
  localparam int HOLD_COUNT  = 3;
  localparam int SLEEP_COUNT = 4;

  typedef enum int {
    HOLD_ADDR = 0,
    HOLD_BACK = 1,
    HOLD_BUS  = 2
  } hold_idx_e;

  typedef enum int {
    SLP_SHUTDOWN = 0,
    SLP_HALT     = 1,
    SLP_STOPGNT  = 2,
    SLP_STOPCLK  = 3
  } sleep_idx_e;
endpackage

// File: rtl/busreq_edge.sv
module busreq_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (clr) prev_q[g] <= 1'b0;
      else     prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
  end
endmodule

// File: rtl/busreq_hold.sv
module busreq_hold #(
  parameter int N_HOLD = busreq_pkg::HOLD_COUNT
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              asleep,
  input  logic [N_HOLD-1:0] hold_off,
  input  logic              starved,
  input  logic              cyc_start,
  output logic              blocked,
  output logic              pending,
  output logic              level,
  output logic              issue
);
  logic pend_q, arm_q, lvl_q;

  assign blocked = |hold_off;
  assign pending = pend_q;
  // level request: blocked and (starved now or already latched)
  assign level   = blocked & (starved | lvl_q);
  // restart strobe: armed one edge earlier, still clear now
  assign issue   = arm_q & ~blocked & ~asleep;

  always_ff @(posedge clk) begin
    if (clr) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      lvl_q  <= blocked & ~asleep & (starved | lvl_q);
      arm_q  <= pend_q & ~blocked & ~asleep & ~arm_q;
      pend_q <= (pend_q & ~issue) | (cyc_start & ~asleep & (blocked | pend_q));
    end
  end
endmodule

// File: rtl/busreq_out.sv
module busreq_out (
  input  logic clk,
  input  logic quiet,
  input  logic direct,
  input  logic issue,
  input  logic cache_pulse,
  input  logic level,
  output logic bus_req,
  output logic ads
);
  logic req_q, ads_q;

  always_ff @(posedge clk) begin
    if (quiet) begin
      req_q <= 1'b0;
      ads_q <= 1'b0;
    end else begin
      req_q <= direct | issue | cache_pulse | level;
      ads_q <= direct | issue;
    end
  end

  assign bus_req = req_q;
  assign ads     = ads_q;
endmodule

// File: rtl/busreq_gen.sv
module busreq_gen #(
  parameter int N_HOLD  = busreq_pkg::HOLD_COUNT,
  parameter int N_SLEEP = busreq_pkg::SLEEP_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init,
  input  logic [N_SLEEP-1:0] sleep_st,
  input  logic [N_HOLD-1:0]  hold_off,
  input  logic               starved,
  input  logic               cyc_start,
  input  logic               cache_store,
  input  logic               tag_recover,
  output logic               bus_req,
  output logic               ads
);
  localparam int N_CACHE = 2;

  logic               clr, asleep, quiet;
  logic               blocked, pending, level, issue, direct;
  logic [N_CACHE-1:0] cache_rise;

  assign clr    = rst | init;
  assign asleep = |sleep_st;
  assign quiet  = clr | asleep;
  assign direct = cyc_start & ~blocked & ~pending & ~quiet;

  busreq_edge #(.WIDTH(N_CACHE)) u_edge (
    .clk  (clk),
    .clr  (rst),
    .lvl  ({tag_recover, cache_store}),
    .rise (cache_rise)
  );

  busreq_hold #(.N_HOLD(N_HOLD)) u_hold (
    .clk       (clk),
    .clr       (clr),
    .asleep    (asleep),
    .hold_off  (hold_off),
    .starved   (starved),
    .cyc_start (cyc_start),
    .blocked   (blocked),
    .pending   (pending),
    .level     (level),
    .issue     (issue)
  );

  busreq_out u_out (
    .clk         (clk),
    .quiet       (quiet),
    .direct      (direct),
    .issue       (issue),
    .cache_pulse (|cache_rise),
    .level       (level),
    .bus_req     (bus_req),
    .ads         (ads)
  );
endmodule

// File: rtl/busreq_gen_chk.sv
module busreq_gen_chk #(
  parameter int N_HOLD  = 3,
  parameter int N_SLEEP = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               init,
  input logic [N_SLEEP-1:0] sleep_st,
  input logic [N_HOLD-1:0]  hold_off,
  input logic               starved,
  input logic               bus_req,
  input logic               ads
);
  a_r1_strobe_has_req: assert property (@(posedge clk) disable iff (rst)
    ads |-> bus_req);

  a_r5_quiet_states: assert property (@(posedge clk) disable iff (rst)
    ((|sleep_st) || init) |=> (!bus_req && !ads));

  a_r3_level_held: assert property (@(posedge clk) disable iff (rst)
    ((|hold_off) && starved && !(|sleep_st) && !init) |=> bus_req);

  a_r7_no_strobe_blocked: assert property (@(posedge clk) disable iff (rst)
    (|hold_off) |=> !ads);

  a_r6_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bus_req && !ads));
endmodule

bind busreq_gen busreq_gen_chk #(.N_HOLD(N_HOLD), .N_SLEEP(N_SLEEP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .init     (init),
  .sleep_st (sleep_st),
  .hold_off (hold_off),
  .starved  (starved),
  .bus_req  (bus_req),
  .ads      (ads)
);

// File: tb/busreq_gen_tb.sv
module busreq_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 48;

  logic       clk = 1'b0;
  logic       rst, init, starved, cyc_start, cache_store, tag_recover;
  logic [3:0] sleep_st;
  logic [2:0] hold_off;
  logic       bus_req, ads;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busreq_gen u_dut (
    .clk(clk), .rst(rst), .init(init), .sleep_st(sleep_st), .hold_off(hold_off),
    .starved(starved), .cyc_start(cyc_start), .cache_store(cache_store),
    .tag_recover(tag_recover), .bus_req(bus_req), .ads(ads)
  );

  // row: tag | rst init sleep[3:0] hold[2:0] starved cyc cs tr | exp_req exp_ads
  localparam logic [18:0] VEC [NV] = '{
    {4'd6,  15'b1_0_0000_000_0000_00}, // R6 reset state
    {4'd1,  15'b0_0_0000_000_0000_00}, // R1 idle
    {4'd1,  15'b0_0_0000_000_0100_11}, // R1 direct cycle
    {4'd1,  15'b0_0_0000_000_0000_00}, // R1 one clock wide
    {4'd2,  15'b0_0_0000_000_0010_10}, // R2 cache store edge
    {4'd2,  15'b0_0_0000_000_0010_00}, // R2 held store, no repeat
    {4'd2,  15'b0_0_0000_000_0001_10}, // R2 tag recovery edge
    {4'd2,  15'b0_0_0000_000_0000_00}, // R2
    {4'd3,  15'b0_0_0000_001_0000_00}, // R3 blocked, not starved
    {4'd7,  15'b0_0_0000_001_0100_00}, // R7 start while blocked
    {4'd3,  15'b0_0_0000_001_1000_10}, // R3 level begins
    {4'd3,  15'b0_0_0000_001_0000_10}, // R3 latched after starved drops
    {4'd3,  15'b0_0_0000_000_0000_00}, // R3 released on negation
    {4'd4,  15'b0_0_0000_000_0000_11}, // R4 restart strobe
    {4'd4,  15'b0_0_0000_000_0000_00}, // R4 single strobe
    {4'd3,  15'b0_0_0000_011_1100_10}, // R3 two hold-offs
    {4'd4,  15'b0_0_0000_010_1000_10}, // R4 one still active
    {4'd4,  15'b0_0_0000_000_0000_00}, // R4 all negated
    {4'd4,  15'b0_0_0000_000_0000_11}, // R4 restart
    {4'd9,  15'b0_0_0000_100_0010_10}, // R9 pulse while blocked
    {4'd9,  15'b0_0_0000_100_0000_00}, // R9
    {4'd7,  15'b0_0_0000_000_0000_00}, // R7 nothing pending
    {4'd5,  15'b0_0_0001_000_0100_00}, // R5 shutdown
    {4'd5,  15'b0_0_0000_000_0000_00}, // R5 start was dropped
    {4'd5,  15'b0_0_0000_000_0000_00}, // R5
    {4'd5,  15'b0_0_0010_000_0010_00}, // R5 halt
    {4'd5,  15'b0_0_0100_001_1000_00}, // R5 stop-grant
    {4'd5,  15'b0_0_1000_000_0001_00}, // R5 stop-clock
    {4'd5,  15'b0_1_0000_000_0100_00}, // R5 init
    {4'd7,  15'b0_0_0000_001_0100_00}, // R7 pending again
    {4'd6,  15'b0_1_0000_001_0000_00}, // R6 init clears pending
    {4'd6,  15'b0_0_0000_000_0000_00}, // R6
    {4'd6,  15'b0_0_0000_000_0000_00}, // R6 no restart
    {4'd8,  15'b0_0_0000_001_0100_00}, // R8 pending
    {4'd8,  15'b0_0_0010_000_0000_00}, // R8 unblocked but asleep
    {4'd8,  15'b0_0_0000_000_0000_00}, // R8 awake, arms
    {4'd8,  15'b0_0_0000_000_0000_11}, // R8 restart
    {4'd3,  15'b0_0_0000_001_1100_10}, // R3 level with pending
    {4'd6,  15'b1_0_0000_001_1000_00}, // R6 reset mid-block
    {4'd6,  15'b0_0_0000_000_0000_00}, // R6
    {4'd6,  15'b0_0_0000_000_0000_00}, // R6 no restart
    {4'd1,  15'b0_0_0000_000_0100_11}, // R1 back to back
    {4'd1,  15'b0_0_0000_000_0100_11}, // R1
    {4'd7,  15'b0_0_0000_001_0100_00}, // R7
    {4'd10, 15'b0_0_0000_000_0000_00}, // R10 arms
    {4'd10, 15'b0_0_0000_001_0000_00}, // R10 hold returns
    {4'd10, 15'b0_0_0000_000_0000_00}, // R10 re-arms
    {4'd10, 15'b0_0_0000_000_0000_11}  // R10 restart
  };

  task automatic drive(input logic [14:0] v);
    @(negedge clk);
    rst = v[14]; init = v[13]; sleep_st = v[12:9]; hold_off = v[8:6];
    starved = v[5]; cyc_start = v[4]; cache_store = v[3]; tag_recover = v[2];
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic got_r, input logic got_a,
                       input logic exp_r, input logic exp_a);
    checks++;
    if (got_r !== exp_r || got_a !== exp_a) begin
      failures++;
      $display("FAIL %s req/ads actual=%b%b expected=%b%b", tag, got_r, got_a, exp_r, exp_a);
    end
  endtask

  initial begin
    int cnt;
    int lat;
    rst = 1'b1; init = 1'b0; sleep_st = '0; hold_off = '0;
    starved = 1'b0; cyc_start = 1'b0; cache_store = 1'b0; tag_recover = 1'b0;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:0]);
      check($sformatf("R%0d row %0d", VEC[i][18:15], i), bus_req, ads,
            VEC[i][1], VEC[i][0]);
    end

    // R3: level held for a twenty-cycle hold-off, starved only at first
    drive(15'b0_0_0000_000_0000_00);
    cnt = 0;
    drive(15'b0_0_0000_010_1100_00);
    if (bus_req) cnt++;
    for (int k = 0; k < 19; k++) begin
      drive(15'b0_0_0000_010_0000_00);
      if (bus_req) cnt++;
    end
    checks++;
    if (cnt != 20) begin
      failures++;
      $display("FAIL R3 held level cycles actual=%0d expected=20", cnt);
    end

    // R4: restart latency counted in samples after negation
    lat = 0;
    for (int k = 1; k <= 4; k++) begin
      drive(15'b0_0_0000_000_0000_00);
      if (ads && lat == 0) lat = k;
    end
    checks++;
    if (lat != 2) begin
      failures++;
      $display("FAIL R4 restart latency actual=%0d expected=2", lat);
    end

    // R6: reset with all activity inputs high
    drive(15'b1_0_0000_000_0111_00);
    check("R6 reset dominates", bus_req, ads, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule